// File: doc/BRIEF.md
# Multi-Channel Memory Copy Engine

This block moves a block of bytes from one memory address to another for several independent channels. Software sets up a channel through a 32-bit register port: a byte count written as length minus one, source and destination addresses, an access-control word for each side, and a control word that launches the copy. One shared mover runs a read beat and then a write beat against a simple request/grant memory master. Each grant is followed by one response cycle that returns read data or acknowledges a write, and that cycle may flag an error. Read data and write data are right-justified on a 64-bit bus. A mover that is shared by all channels serves them round-robin, one burst at a time.

The width of each beat is the largest of 1, 2, 4 or 8 bytes that the access-control words permit, that both current addresses are aligned to, and that does not run past the end of the block. Bytes outside the requested range are never written. When a copy ends, each channel latches a 4-bit end code and raises its own interrupt line. Software acknowledges it by writing zero to the code. A global enable stalls all channels without losing their progress. Clearing a channel's enable while it is busy abandons its copy.

Top module: `dma_m2m`

## Requirements
- R1: After reset every register reads 0, every interrupt line is low and no memory request is made.
- R2: The count register holds the byte count minus one: writing 0 copies exactly one byte, and writing N copies N+1 bytes.
- R3: While bit 28 of the global register (offset 0x00) is 0, no read request is issued. Setting the bit lets pending copies proceed.
- R4: A copy starts only when a write to the control register (+0x28) sets both bit 28 (channel enable) and bit 24 (start). Setting the enable alone moves nothing.
- R5: A copy that completes writes end code 0x8 into bits 3:0 of the status register (+0x30). The channel interrupt is high when bit 0 of the control word is set. Writing 0 to the status clears the code and the interrupt.
- R6: An error response stops the channel with end code 0x1 and no further request. The interrupt rises only when bit 1 of the control word is set.
- R7: Beat width is 2^k bytes with k ≤ min(source, destination) burst-size field (bits 17:16 of +0x1C and +0x20), both addresses aligned to 2^k and remaining bytes ≥ 2^k. The largest such k is used.
- R8: The source burst-length field (bits 11:8 of +0x1C) holds L. A channel keeps the mover for L+1 beats, after which the next busy channel in round-robin order is served.
- R9: Writing the control register with bit 28 clear to a busy channel ends its copy: no write follows an unissued read, the status stays 0 and no interrupt rises.
- R10: Writes to the count, address and access-control registers of a busy channel are ignored.
- R11: Channel n's registers sit at n·0x30 plus the offsets above: count +0x10, source +0x14, destination +0x18.
- R12: Bit 28 of the control register reads 1 while the channel is busy and 0 after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address of the beat |
| mem_size_o | output | 2 | Beat width code (2^code bytes) |
| mem_wdata_o | output | 64 | Write data, right-justified |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Response cycle |
| mem_rdata_i | input | 64 | Read data, right-justified |
| mem_err_i | input | 1 | Error flag in the response cycle |
| irq_o | output | NCH | Per-channel interrupt |

## Verification
The bench aims at beat sizing with odd start addresses, short tails and a narrow burst-size code. A design that mis-sized a beat would write too many beats, or write bytes past the end of the block, and the full-memory compare catches both. It checks the one-byte copy from a zero count, which an off-by-one count would turn into zero or two bytes. An error response is injected part-way through a copy, and the partial result and the interrupt gating are checked with both enable settings. Two channels contend with two-beat bursts to expose wrong arbitration order, an abort is issued under a stalled grant, and a channel is kept waiting under the global enable to show that its register writes are ignored.

// File: rtl/dma_m2m_pkg.sv
package dma_m2m_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  localparam logic [7:0] OFF_GLB = 8'h00;
  localparam logic [7:0] OFF_CNT = 8'h10;
  localparam logic [7:0] OFF_SRC = 8'h14;
  localparam logic [7:0] OFF_DST = 8'h18;
  localparam logic [7:0] OFF_SAC = 8'h1C;
  localparam logic [7:0] OFF_DAC = 8'h20;
  localparam logic [7:0] OFF_CTL = 8'h28;
  localparam logic [7:0] OFF_STS = 8'h30;
  localparam int         STRIDE  = 48;

  localparam int GEN_BIT = 28;
  localparam int CE_BIT  = 28;
  localparam int SE_BIT  = 24;
  localparam int EI_BIT  = 1;
  localparam int TI_BIT  = 0;

  localparam logic [3:0] END_OK  = 4'h8;
  localparam logic [3:0] END_ERR = 4'h1;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [31:0]       rem;  // bytes left minus one
    logic [1:0]        bs;   // min of both size codes
    logic [3:0]        bl;
  } chan_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT
  } eng_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_m2m_pkg::*; #(
  parameter int CH     = 0,
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] upd_src_i,
  input  logic [ADDR_W-1:0] upd_dst_i,
  input  logic [31:0]       upd_rem_i,
  input  logic              end_i,
  input  logic [3:0]        end_code_i,
  output logic              busy_o,
  output chan_cfg_t         cfg_o,
  output logic              irq_o
);
  localparam logic [REG_AW-1:0] BASE = REG_AW'(CH * STRIDE);

  logic [REG_AW-1:0] off;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [31:0]       rem_q;
  logic [1:0]        sbs_q, dbs_q;
  logic [3:0]        sbl_q, dbl_q, tf_q, sts_q;
  logic              busy_q, se_q, ei_q, ti_q;
  logic hit_cnt, hit_src, hit_dst, hit_sac, hit_dac, hit_ctl, hit_sts;

  assign off     = addr_i - BASE;
  assign hit_cnt = off == REG_AW'(OFF_CNT);
  assign hit_src = off == REG_AW'(OFF_SRC);
  assign hit_dst = off == REG_AW'(OFF_DST);
  assign hit_sac = off == REG_AW'(OFF_SAC);
  assign hit_dac = off == REG_AW'(OFF_DAC);
  assign hit_ctl = off == REG_AW'(OFF_CTL);
  assign hit_sts = off == REG_AW'(OFF_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; rem_q <= '0;
      sbs_q <= '0; dbs_q <= '0; sbl_q <= '0; dbl_q <= '0;
      tf_q <= '0; sts_q <= '0; busy_q <= 1'b0;
      se_q <= 1'b0; ei_q <= 1'b0; ti_q <= 1'b0;
    end else begin
      if (upd_i) begin
        src_q <= upd_src_i; dst_q <= upd_dst_i; rem_q <= upd_rem_i;
      end
      if (end_i && busy_q) begin
        busy_q <= 1'b0;
        sts_q  <= end_code_i;
      end
      if (wr_i) begin
        if (!busy_q) begin
          if (hit_cnt) rem_q <= wdata_i;
          if (hit_src) src_q <= wdata_i;
          if (hit_dst) dst_q <= wdata_i;
          if (hit_sac) begin sbs_q <= wdata_i[17:16]; sbl_q <= wdata_i[11:8]; end
          if (hit_dac) begin dbs_q <= wdata_i[17:16]; dbl_q <= wdata_i[11:8]; end
          if (hit_ctl) begin
            se_q <= wdata_i[SE_BIT];
            tf_q <= wdata_i[23:20];
            ei_q <= wdata_i[EI_BIT];
            ti_q <= wdata_i[TI_BIT];
            if (wdata_i[CE_BIT] && wdata_i[SE_BIT]) begin
              busy_q <= 1'b1;
              sts_q  <= '0;
            end
          end
        end else if (hit_ctl && !wdata_i[CE_BIT]) begin
          busy_q <= 1'b0;  // abort
        end
        if (hit_sts && wdata_i[3:0] == 4'h0) sts_q <= '0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_cnt) rdata_o = rem_q;
    if (hit_src) rdata_o = src_q;
    if (hit_dst) rdata_o = dst_q;
    if (hit_sac) rdata_o = {14'b0, sbs_q, 4'b0, sbl_q, 8'b0};
    if (hit_dac) rdata_o = {14'b0, dbs_q, 4'b0, dbl_q, 8'b0};
    if (hit_ctl) rdata_o = {3'b0, busy_q, 3'b0, se_q, tf_q, 18'b0, ei_q, ti_q};
    if (hit_sts) rdata_o = {28'b0, sts_q};
  end

  assign busy_o    = busy_q;
  assign cfg_o.src = src_q;
  assign cfg_o.dst = dst_q;
  assign cfg_o.rem = rem_q;
  assign cfg_o.bs  = (sbs_q < dbs_q) ? sbs_q : dbs_q;
  assign cfg_o.bl  = sbl_q;
  assign irq_o     = (sts_q == END_OK) ? ti_q : ((sts_q != 4'h0) && ei_q);
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int NCH   = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  // smallest offset after the last grant wins
  always_comb begin
    gnt_idx_o = ptr_q;
    for (int k = NCH; k >= 1; k--) begin
      if (req_i[(int'(ptr_q) + k) % NCH]) gnt_idx_o = IDX_W'((int'(ptr_q) + k) % NCH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= IDX_W'(NCH - 1);
    else if (take_i) ptr_q <= gnt_idx_o;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine import dma_m2m_pkg::*; #(
  parameter int NCH   = 2,
  parameter int IDX_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              g_en_i,
  input  logic [NCH-1:0]    busy_i,
  input  chan_cfg_t         cfg_i [NCH],
  input  logic [IDX_W-1:0]  arb_idx_i,
  output logic              take_o,
  output logic [IDX_W-1:0]  act_o,
  output logic              upd_o,
  output logic [ADDR_W-1:0] upd_src_o,
  output logic [ADDR_W-1:0] upd_dst_o,
  output logic [31:0]       upd_rem_o,
  output logic              end_o,
  output logic [3:0]        end_code_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_err_i
);
  eng_state_e        st_q;
  logic [IDX_W-1:0]  cur_q;
  logic [3:0]        beat_q;
  logic [1:0]        sz_q, sz_c;
  logic [DATA_W-1:0] buf_q;
  chan_cfg_t         cfg;
  logic [31:0]       wbytes;
  logic              last, run, err_rsp;

  assign cfg    = cfg_i[cur_q];
  assign run    = busy_i[cur_q] && g_en_i;
  assign wbytes = 32'd1 << sz_q;
  assign last   = cfg.rem < wbytes;

  // widest beat allowed by size code, alignment and remaining bytes
  always_comb begin
    sz_c = 2'd0;
    for (int k = 1; k < 4; k++) begin
      if (k <= int'(cfg.bs) &&
          (cfg.src & ((32'd1 << k) - 32'd1)) == 32'd0 &&
          (cfg.dst & ((32'd1 << k) - 32'd1)) == 32'd0 &&
          cfg.rem >= ((32'd1 << k) - 32'd1))
        sz_c = 2'(k);
    end
  end

  assign err_rsp     = (st_q == ST_RD_WAIT || st_q == ST_WR_WAIT) && mem_rvalid_i && mem_err_i;
  assign take_o      = (st_q == ST_IDLE) && g_en_i && (|busy_i);
  assign act_o       = cur_q;
  assign upd_o       = (st_q == ST_WR_WAIT) && mem_rvalid_i && !mem_err_i;
  assign upd_src_o   = cfg.src + wbytes;
  assign upd_dst_o   = cfg.dst + wbytes;
  assign upd_rem_o   = last ? 32'd0 : cfg.rem - wbytes;
  assign end_o       = err_rsp || (upd_o && last);
  assign end_code_o  = err_rsp ? END_ERR : END_OK;
  assign mem_req_o   = ((st_q == ST_RD_REQ) && run) || (st_q == ST_WR_REQ);
  assign mem_we_o    = st_q == ST_WR_REQ;
  assign mem_addr_o  = (st_q == ST_WR_REQ) ? cfg.dst : cfg.src;
  assign mem_size_o  = (st_q == ST_WR_REQ) ? sz_q : sz_c;
  assign mem_wdata_o = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cur_q <= '0; beat_q <= '0; sz_q <= '0; buf_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take_o) begin
          cur_q <= arb_idx_i; beat_q <= '0; st_q <= ST_RD_REQ;
        end
        ST_RD_REQ:
          if (!run)           st_q <= ST_IDLE;
          else if (mem_gnt_i) begin sz_q <= sz_c; st_q <= ST_RD_WAIT; end
        ST_RD_WAIT: if (mem_rvalid_i) begin
          if (mem_err_i || !busy_i[cur_q]) st_q <= ST_IDLE;
          else begin buf_q <= mem_rdata_i; st_q <= ST_WR_REQ; end
        end
        ST_WR_REQ: if (mem_gnt_i) st_q <= ST_WR_WAIT;
        ST_WR_WAIT: if (mem_rvalid_i) begin
          if (mem_err_i || last || !run || beat_q == cfg.bl) st_q <= ST_IDLE;
          else begin beat_q <= beat_q + 4'd1; st_q <= ST_RD_REQ; end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_m2m.sv
module dma_m2m import dma_m2m_pkg::*; #(
  parameter int NCH    = 2,
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic [NCH-1:0]    irq_o
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic              g_en_q;
  logic [NCH-1:0]    busy;
  chan_cfg_t         cfg [NCH];
  logic [REG_W-1:0]  ch_rdata [NCH];
  logic [IDX_W-1:0]  arb_idx, act;
  logic              take, upd, end_v;
  logic [ADDR_W-1:0] upd_src, upd_dst;
  logic [31:0]       upd_rem;
  logic [3:0]        end_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) g_en_q <= 1'b0;
    else if (reg_wr_i && reg_addr_i == REG_AW'(OFF_GLB)) g_en_q <= reg_wdata_i[GEN_BIT];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_regs #(.CH(c), .REG_AW(REG_AW)) regs_i (
      .clk_i, .rst_ni,
      .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(ch_rdata[c]),
      .upd_i(upd && act == IDX_W'(c)), .upd_src_i(upd_src), .upd_dst_i(upd_dst),
      .upd_rem_i(upd_rem), .end_i(end_v && act == IDX_W'(c)), .end_code_i(end_code),
      .busy_o(busy[c]), .cfg_o(cfg[c]), .irq_o(irq_o[c])
    );
  end

  always_comb begin
    reg_rdata_o = (reg_addr_i == REG_AW'(OFF_GLB)) ? {3'b0, g_en_q, 28'b0} : '0;
    for (int c = 0; c < NCH; c++) reg_rdata_o = reg_rdata_o | ch_rdata[c];
  end

  dma_rr_arb #(.NCH(NCH), .IDX_W(IDX_W)) arb_i (
    .clk_i, .rst_ni, .req_i(busy), .take_i(take), .gnt_idx_o(arb_idx)
  );

  dma_engine #(.NCH(NCH), .IDX_W(IDX_W)) eng_i (
    .clk_i, .rst_ni, .g_en_i(g_en_q), .busy_i(busy), .cfg_i(cfg), .arb_idx_i(arb_idx),
    .take_o(take), .act_o(act), .upd_o(upd), .upd_src_o(upd_src), .upd_dst_o(upd_dst),
    .upd_rem_o(upd_rem), .end_o(end_v), .end_code_o(end_code),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_size_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i, .mem_err_i
  );
endmodule

// File: rtl/dma_m2m_chk.sv
module dma_m2m_chk #(
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_wr_i,
  input logic           g_en_i,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [31:0]    mem_addr_o,
  input logic [1:0]     mem_size_o,
  input logic           mem_gnt_i,
  input logic           mem_rvalid_i,
  input logic           mem_err_i,
  input logic [NCH-1:0] irq_o
);
  // R3
  rd_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> g_en_i);

  // R7
  beat_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o & ((32'd1 << mem_size_o) - 32'd1)) == 32'd0));

  // R7
  wr_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_gnt_i) |=>
      (mem_req_o && mem_we_o && $stable(mem_addr_o) && $stable(mem_size_o)));

  // R6
  err_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rvalid_i && mem_err_i) |=> !mem_req_o);

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    // R5
    irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[c]) |-> $past(reg_wr_i));
  end
endmodule

bind dma_m2m dma_m2m_chk #(.NCH(NCH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .g_en_i(g_en_q),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_size_o(mem_size_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
  .mem_err_i(mem_err_i), .irq_o(irq_o)
);

// File: tb/dma_m2m_tb_top.sv
module dma_m2m_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int NVEC = 6;
  // {src, dst, count-1, size code, expected write beats}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h00, 8'h40, 8'd15, 8'd3, 8'd2},
    {8'h01, 8'h41, 8'd6,  8'd3, 8'd3},
    {8'h03, 8'h50, 8'd3,  8'd3, 8'd4},
    {8'h10, 8'h60, 8'd0,  8'd3, 8'd1},
    {8'h20, 8'h70, 8'd7,  8'd1, 8'd4},
    {8'h08, 8'h88, 8'd10, 8'd2, 8'd4}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic [63:0] mem_wdata_o;
  logic        mem_gnt_i;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_err_i = 1'b0;
  logic [NCH-1:0] irq_o;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0] wlog [16];
  int         wr_cnt = 0;
  int         rd_cnt = 0;
  logic       mem_ready = 1'b1;
  logic       err_en = 1'b0;
  logic [7:0] err_addr = '0;
  int         errs = 0;
  int         checks = 0;

  assign mem_gnt_i = mem_ready;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_m2m #(.NCH(NCH), .REG_AW(8)) dut_i (.*);

  // memory model: one response cycle after each grant
  always @(posedge clk_i) begin
    mem_rvalid_i <= 1'b0;
    mem_err_i    <= 1'b0;
    if (mem_req_o && mem_gnt_i) begin
      mem_rvalid_i <= 1'b1;
      if (err_en && mem_addr_o[7:0] == err_addr) mem_err_i <= 1'b1;
      else if (mem_we_o) begin
        for (int b = 0; b < (1 << mem_size_o); b++)
          mem[8'(mem_addr_o[7:0] + b)] = mem_wdata_o[8*b +: 8];
        if (wr_cnt < 16) wlog[wr_cnt] = mem_addr_o[7:0];
        wr_cnt = wr_cnt + 1;
      end else begin
        logic [63:0] d;
        d = '0;
        for (int b = 0; b < (1 << mem_size_o); b++) d[8*b +: 8] = mem[8'(mem_addr_o[7:0] + b)];
        mem_rdata_i <= d;
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_end(input int ch, output logic [31:0] sts);
    sts = '0;
    for (int t = 0; t < 3000 && sts == 0; t++) rd(8'(ch*48 + 'h30), sts);
  endtask

  task automatic setup(input int ch, input logic [7:0] s, input logic [7:0] d,
                       input logic [7:0] n, input logic [1:0] bs, input logic [3:0] bl);
    logic [7:0] b;
    b = 8'(ch*48);
    wr(b + 8'h10, {24'b0, n});
    wr(b + 8'h14, {24'b0, s});
    wr(b + 8'h18, {24'b0, d});
    wr(b + 8'h1C, {14'b0, bs, 4'b0, bl, 8'b0});
    wr(b + 8'h20, {14'b0, bs, 4'b0, 4'hF, 8'b0});
  endtask

  task automatic shadow_copy(input logic [7:0] s, input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) shadow[8'(d + i)] = shadow[8'(s + i)];
  endtask

  task automatic mem_cmp(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'hA5; shadow[i] = 8'(i) ^ 8'hA5; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk(v == 0, "R1 global", v, 0);
    rd(8'h30, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h28, v); chk(v == 0, "R1 ctl", v, 0);
    chk(irq_o == 0 && !mem_req_o, "R1 irq/req", {irq_o, mem_req_o}, 0);

    // R11 bank placement
    wr(8'h44, 32'h1234_5678);
    wr(8'h14, 32'h0000_00AB);
    rd(8'h44, v); chk(v == 32'h1234_5678, "R11 ch1 src", v, 32'h1234_5678);
    rd(8'h14, v); chk(v == 32'hAB, "R11 ch0 src", v, 32'hAB);

    wr(8'h00, 32'h1000_0000);

    // vector table: R2, R5, R7
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] s, d, n, bs, beats;
      {s, d, n, bs, beats} = VEC[k];
      setup(0, s, d, n, bs[1:0], 4'hF);
      wr_cnt = 0;
      wr(8'h28, 32'h1100_0001);
      wait_end(0, v);
      chk(v == 8, "R5 end code", v, 8);
      chk(irq_o[0] == 1'b1, "R5 irq", irq_o[0], 1);
      chk(wr_cnt == int'(beats), "R7 beat count", wr_cnt, beats);
      shadow_copy(s, d, int'(n) + 1);
      mem_cmp("R2 R7 memory");
      wr(8'h30, 32'h0);
      rd(8'h30, v); chk(v == 0 && irq_o[0] == 1'b0, "R5 ack", {v[3:0], irq_o[0]}, 0);
    end
    rd(8'h28, v); chk(v[28] == 1'b0, "R12 ce after end", v[28], 0);

    // R4 enable without start
    wr_cnt = 0;
    setup(0, 8'h00, 8'h90, 8'd3, 2'd0, 4'hF);
    wr(8'h28, 32'h1000_0001);
    repeat (20) @(negedge clk_i);
    rd(8'h28, v);
    chk(wr_cnt == 0 && v[28] == 1'b0, "R4 no start", {wr_cnt[3:0], v[28]}, 0);

    // R3 global gate, R10 busy writes ignored, R12 busy readback
    wr(8'h00, 32'h0);
    setup(1, 8'h80, 8'hD0, 8'd3, 2'd3, 4'hF);
    rd_cnt = 0; wr_cnt = 0;
    wr(8'h58, 32'h1100_0001);
    repeat (30) @(negedge clk_i);
    chk(rd_cnt == 0 && wr_cnt == 0, "R3 gated", rd_cnt + wr_cnt, 0);
    rd(8'h58, v); chk(v[28] == 1'b1, "R12 busy ce", v[28], 1);
    wr(8'h40, 32'h0000_0055);
    wr(8'h48, 32'h0000_0011);
    rd(8'h40, v); chk(v == 3, "R10 count kept", v, 3);
    rd(8'h48, v); chk(v == 32'hD0, "R10 dst kept", v, 32'hD0);
    wr(8'h00, 32'h1000_0000);
    wait_end(1, v);
    chk(v == 8 && irq_o[1], "R3 resumes", v, 8);
    shadow_copy(8'h80, 8'hD0, 4);
    mem_cmp("R3 memory");
    wr(8'h60, 32'h0);

    // R6 error response, interrupt gated by bit 1
    err_en = 1'b1; err_addr = 8'h33;
    setup(0, 8'h30, 8'hE0, 8'd7, 2'd0, 4'hF);
    wr_cnt = 0;
    wr(8'h28, 32'h1100_0001);
    wait_end(0, v);
    chk(v == 1, "R6 err code", v, 1);
    chk(irq_o[0] == 1'b0, "R6 irq masked", irq_o[0], 0);
    chk(wr_cnt == 3, "R6 partial", wr_cnt, 3);
    shadow_copy(8'h30, 8'hE0, 3);
    wr(8'h30, 32'h0);
    setup(0, 8'h30, 8'hE8, 8'd7, 2'd0, 4'hF);
    wr(8'h28, 32'h1100_0002);
    wait_end(0, v);
    chk(v == 1 && irq_o[0], "R6 irq enabled", {v[3:0], irq_o[0]}, 5'h3);
    shadow_copy(8'h30, 8'hE8, 3);
    mem_cmp("R6 memory");
    wr(8'h30, 32'h0);
    err_en = 1'b0;

    // R9 abort under stalled grant
    mem_ready = 1'b0;
    setup(0, 8'h00, 8'hF0, 8'd15, 2'd3, 4'hF);
    wr_cnt = 0;
    wr(8'h28, 32'h1100_0003);
    repeat (5) @(negedge clk_i);
    wr(8'h28, 32'h0000_0003);
    mem_ready = 1'b1;
    repeat (30) @(negedge clk_i);
    rd(8'h30, v);
    chk(wr_cnt == 0 && v == 0 && irq_o[0] == 1'b0, "R9 abort", {wr_cnt[3:0], v[3:0], irq_o[0]}, 0);
    rd(8'h28, v); chk(v[28] == 1'b0, "R9 ce cleared", v[28], 0);

    // R8 two-beat bursts alternate between channels
    setup(0, 8'h00, 8'hA0, 8'd7, 2'd0, 4'h1);
    setup(1, 8'h40, 8'hC0, 8'd7, 2'd0, 4'h1);
    wr_cnt = 0;
    wr(8'h28, 32'h1100_0001);
    wr(8'h58, 32'h1100_0001);
    wait_end(0, v);
    chk(v == 8, "R8 ch0 end", v, 8);
    wait_end(1, v);
    chk(v == 8, "R8 ch1 end", v, 8);
    chk({wlog[0], wlog[1], wlog[2], wlog[3]} == 32'hA0A1_C0C1, "R8 order",
        {wlog[0], wlog[1], wlog[2], wlog[3]}, 32'hA0A1_C0C1);
    shadow_copy(8'h00, 8'hA0, 8);
    shadow_copy(8'h40, 8'hC0, 8);
    mem_cmp("R8 memory");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule